// File: doc/BRIEF.md
# Translation Cache with Single-Level Table Walk

This block turns virtual addresses into physical addresses using 4 KiB pages. A small fully associative cache keeps recent page translations: the frame number and two permission flags, one for reads and one for writes. On a hit the answer comes back the cycle after the request. On a miss the block builds the address of the page-table entry from a base register input and reads that entry over a simple request/response port. It then decides the outcome. An invalid entry gives a segmentation fault. A valid entry that forbids the access gives a protection fault. A valid entry that permits the access completes the request and is written into the cache.

Only one translation is in flight at a time. While a walk runs, `busy` is high and new requests are ignored. A `flush` input clears every cached translation in one cycle, for example after the page table has been rewritten.

Top module: `xlat_cache_walker`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req` are low, `rsp_paddr` is zero, `rsp_fault` is 0, and the cache holds no translation.
- R2: A request accepted while idle (`req_valid` high and `busy` low) that hits a cached, permitted translation raises `rsp_valid` for one cycle, starting the cycle after acceptance. That response carries fault code 0 and `rsp_paddr` = {frame, vaddr[11:0]}.
- R3: A cache hit whose permission flag for the access type is clear gives fault code 2 and `rsp_paddr` zero. Reads need the read flag and writes (`req_write`=1) need the write flag.
- R4: On a miss, `mem_req` is high for exactly one cycle, the cycle after acceptance, with `mem_addr` = `pt_base` + 4 × vaddr[31:12]. `busy` is high from that cycle onward.
- R5: A fetched entry (`mem_rsp_data`) with bit 0 (valid) clear gives fault code 1 with `rsp_paddr` zero, and inserts nothing, so the same page walks again.
- R6: A fetched entry with bit 0 set but the needed flag clear gives fault code 2 with `rsp_paddr` zero, and inserts nothing. The read flag is bit 1 and the write flag is bit 2.
- R7: A fetched entry that is valid and permits the access gives fault code 0 with `rsp_paddr` = {`mem_rsp_data`[31:12], vaddr[11:0]}. Its frame and flags are inserted, so the next access to that page hits without `mem_req`.
- R8: The cache has 8 entries, and inserts fill them in round-robin order. The victim pointer advances only on an insert and is not reset by a flush. After a flush, nine distinct fills evict the first one.
- R9: A cycle with `flush` high invalidates all entries, so the next access to any page walks. When a flush and an insert fall on the same edge, the flush wins.
- R10: The walk response is taken in the cycle `mem_rsp_valid` is high. `rsp_valid` follows in the next cycle, and `busy` falls at the same point. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate every cached translation |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| pt_base | input | 32 | Physical base address of the page table |
| busy | output | 1 | A walk is in progress; requests are ignored |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 segmentation, 2 protection |
| mem_req | output | 1 | Page-table read request, one cycle |
| mem_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read data valid |
| mem_rsp_data | input | 32 | Entry: [31:12] frame, bit 2 write, bit 1 read, bit 0 valid |

## Verification
A hit's result is due in the cycle after the accepting edge. A miss puts out `mem_req` in that same cycle. The walk result is due one cycle after the edge that samples `mem_rsp_valid`, and `busy` drops in that cycle. The bench keeps a behavioural model that updates on each rising edge from the same inputs the design sees. It compares `busy`, `rsp_valid` and `mem_req` on every falling edge. It compares address and fault whenever a response or request is predicted, so any lost or extra cycle of latency shows up at the exact cycle it occurs.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_REQ  = 2'd1,
    WS_WAIT = 2'd2
  } walk_st_e;

  // Entry flag positions inside a page-table word
  localparam int FLAG_V = 0;
  localparam int FLAG_R = 1;
  localparam int FLAG_W = 2;

  function automatic logic perm_ok(input logic rd_ok, input logic wr_ok, input logic is_wr);
    return is_wr ? wr_ok : rd_ok;
  endfunction
endpackage

// File: rtl/xw_tlb_array.sv
module xw_tlb_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_r,
  output logic             lk_w,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic             ins_r,
  input  logic             ins_w
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   frm_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q, wr_q;
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);

    always_ff @(posedge clk) begin
      if (ins_en && (ptr_q == IDX_W'(i))) begin
        tag_q[i] <= ins_vpn;
        frm_q[i] <= ins_pfn;
        rd_q[i]  <= ins_r;
        wr_q[i]  <= ins_w;
      end
    end
  end

  always_comb begin
    lk_hit = |match;
    lk_pfn = '0;
    lk_r   = 1'b0;
    lk_w   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_pfn = frm_q[i];
        lk_r   = rd_q[i];
        lk_w   = wr_q[i];
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (ins_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
    if (flush) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
  import xw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [VA_W-1:0]                  req_vaddr,
  input  logic                             req_write,
  input  logic [PTE_W-1:0]                 pt_base,
  output logic [VA_W-PAGE_SHIFT-1:0]       lk_vpn,
  input  logic                             lk_hit,
  input  logic [PTE_W-PAGE_SHIFT-1:0]      lk_pfn,
  input  logic                             lk_r,
  input  logic                             lk_w,
  output logic                             ins_en,
  output logic [VA_W-PAGE_SHIFT-1:0]       ins_vpn,
  output logic [PTE_W-PAGE_SHIFT-1:0]      ins_pfn,
  output logic                             ins_r,
  output logic                             ins_w,
  output logic                             busy,
  output logic                             mem_req,
  output logic [PTE_W-1:0]                 mem_addr,
  input  logic                             mem_rsp_valid,
  input  logic [PTE_W-1:0]                 mem_rsp_data,
  output logic                             rsp_valid,
  output logic [PTE_W-1:0]                 rsp_paddr,
  output fault_e                           rsp_fault
);
  localparam int PA_W  = PTE_W;
  localparam int VPN_W = VA_W - PAGE_SHIFT;

  walk_st_e        st_q, st_d;
  logic [VA_W-1:0] va_q, va_d;
  logic            wr_q, wr_d;
  logic            rv_q, rv_d;
  logic [PA_W-1:0] pa_q, pa_d;
  fault_e          ft_q, ft_d;
  logic            pte_unused;

  assign pte_unused = ^mem_rsp_data[PAGE_SHIFT-1:FLAG_W+1];

  assign lk_vpn   = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign ins_vpn  = va_q[VA_W-1:PAGE_SHIFT];
  assign ins_pfn  = mem_rsp_data[PTE_W-1:PAGE_SHIFT];
  assign ins_r    = mem_rsp_data[FLAG_R];
  assign ins_w    = mem_rsp_data[FLAG_W];
  assign busy     = (st_q != WS_IDLE);
  assign mem_req  = (st_q == WS_REQ);
  assign mem_addr = pt_base + PA_W'({va_q[VA_W-1:PAGE_SHIFT], 2'b00});
  assign rsp_valid = rv_q;
  assign rsp_paddr = pa_q;
  assign rsp_fault = ft_q;

  always_comb begin
    st_d   = st_q;
    va_d   = va_q;
    wr_d   = wr_q;
    rv_d   = 1'b0;
    pa_d   = pa_q;
    ft_d   = ft_q;
    ins_en = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          va_d = req_vaddr;
          wr_d = req_write;
          if (lk_hit) begin
            rv_d = 1'b1;
            if (perm_ok(lk_r, lk_w, req_write)) begin
              pa_d = {lk_pfn, req_vaddr[PAGE_SHIFT-1:0]};
              ft_d = FLT_NONE;
            end else begin
              pa_d = '0;
              ft_d = FLT_PROT;
            end
          end else begin
            st_d = WS_REQ;
          end
        end
      end
      WS_REQ: st_d = WS_WAIT;
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          rv_d = 1'b1;
          st_d = WS_IDLE;
          if (!mem_rsp_data[FLAG_V]) begin
            pa_d = '0;
            ft_d = FLT_SEG;
          end else if (!perm_ok(mem_rsp_data[FLAG_R], mem_rsp_data[FLAG_W], wr_q)) begin
            pa_d = '0;
            ft_d = FLT_PROT;
          end else begin
            pa_d   = {mem_rsp_data[PTE_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
            ft_d   = FLT_NONE;
            ins_en = 1'b1;
          end
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WS_IDLE;
      rv_q <= 1'b0;
      pa_q <= '0;
      ft_q <= FLT_NONE;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      pa_q <= pa_d;
      ft_q <= ft_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == WS_IDLE) begin
      va_q <= va_d;
      wr_q <= wr_d;
    end
  end
endmodule

// File: rtl/xlat_cache_walker.sv
module xlat_cache_walker #(
  parameter int VA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [PTE_W-1:0] pt_base,
  output logic             busy,
  output logic             rsp_valid,
  output logic [PTE_W-1:0] rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req,
  output logic [PTE_W-1:0] mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PFN_W = PTE_W - PAGE_SHIFT;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [VPN_W-1:0] lk_vpn, ins_vpn;
  logic [PFN_W-1:0] lk_pfn, ins_pfn;
  logic             lk_hit, lk_r, lk_w, ins_en, ins_r, ins_w;
  xw_pkg::fault_e   fault;

  xw_tlb_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
    .clk(clk), .rst_n(rst_core_n), .flush(flush),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_r(lk_r), .lk_w(lk_w),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_r(ins_r), .ins_w(ins_w)
  );

  xw_walk_ctrl #(.VA_W(VA_W), .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
    .clk(clk), .rst_n(rst_core_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(pt_base),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_r(lk_r), .lk_w(lk_w),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_r(ins_r), .ins_w(ins_w),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(fault)
  );

  assign rsp_fault = fault;
endmodule

// File: rtl/xlat_cache_walker_chk.sv
module xlat_cache_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            busy,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_req
);
  // R4: a table read lasts one cycle and the walk stays busy after it
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req |=> (!mem_req && busy));

  // R4: a walk always opens with a table read
  p_walk_start_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(busy) |-> mem_req);

  // R10: the end of a walk always delivers a result
  p_walk_done_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(busy) |-> rsp_valid);

  // R10: no result is delivered while a walk is open
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |-> !busy);

  // R5, R6: faults carry a zeroed address and a legal code
  p_fault_addr_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && rsp_fault != 2'd3));
endmodule

bind xlat_cache_walker xlat_cache_walker_chk #(.PA_W(PTE_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_q[1]), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req)
);

// File: tb/xlat_cache_walker_tb_top.sv
module xlat_cache_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] pt_base = 32'h0008_0000;
  logic        busy, rsp_valid, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic [1:0]  rsp_fault;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  xlat_cache_walker dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(pt_base),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";

  // Page table contents keyed by virtual page number
  logic [31:0] ptab [int];

  function automatic logic [31:0] mk_pte(input logic [19:0] frame, input logic v,
                                         input logic r, input logic w);
    return {frame, 9'd0, w, r, v};
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          s0 = 0, s1 = 0;
  int          m_state = 0;
  logic [31:0] m_va = '0;
  logic        m_wr = 1'b0;
  bit          e_rv = 0;
  logic [31:0] e_pa = '0;
  logic [1:0]  e_ft = '0;
  logic [19:0] c_vpn [8];
  logic [19:0] c_frm [8];
  bit          c_r [8], c_w [8], c_v [8];
  int          c_ptr = 0;

  task automatic m_reset();
    m_state = 0; e_rv = 0; e_pa = '0; e_ft = '0; c_ptr = 0;
    for (int i = 0; i < 8; i++) c_v[i] = 0;
  endtask

  task automatic m_step();
    int hit;
    logic [31:0] d;
    bit ok;
    e_rv = 0;
    if (m_state == 0) begin
      if (req_valid) begin
        m_va = req_vaddr; m_wr = req_write;
        hit = -1;
        for (int i = 0; i < 8; i++) if (c_v[i] && c_vpn[i] == req_vaddr[31:12]) hit = i;
        if (hit >= 0) begin
          e_rv = 1;
          ok = req_write ? c_w[hit] : c_r[hit];
          if (ok) begin e_pa = {c_frm[hit], req_vaddr[11:0]}; e_ft = 2'd0; end
          else    begin e_pa = '0; e_ft = 2'd2; end
        end else m_state = 1;
      end
    end else if (m_state == 1) begin
      m_state = 2;
    end else if (mem_rsp_valid) begin
      e_rv = 1; m_state = 0; d = mem_rsp_data;
      if (!d[0]) begin e_pa = '0; e_ft = 2'd1; end
      else if (!(m_wr ? d[2] : d[1])) begin e_pa = '0; e_ft = 2'd2; end
      else begin
        e_pa = {d[31:12], m_va[11:0]}; e_ft = 2'd0;
        c_vpn[c_ptr] = m_va[31:12]; c_frm[c_ptr] = d[31:12];
        c_r[c_ptr] = d[1]; c_w[c_ptr] = d[2]; c_v[c_ptr] = 1;
        c_ptr = (c_ptr + 1) % 8;
      end
    end
    if (flush) for (int i = 0; i < 8; i++) c_v[i] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 = 0; s1 = 0; m_reset();
    end else begin
      bit live;
      live = s1; s1 = s0; s0 = 1;
      if (!live) m_reset(); else m_step();
    end
  end

  // ---------------- comparison on every falling edge ----------------
  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("busy", {31'd0, busy}, {31'd0, m_state != 0});
    cmp("rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
    cmp("mem_req", {31'd0, mem_req}, {31'd0, m_state == 1});
    if (e_rv || m_state == 0) begin
      cmp("rsp_paddr", rsp_paddr, e_pa);
      cmp("rsp_fault", {30'd0, rsp_fault}, {30'd0, e_ft});
    end
    if (m_state == 1) cmp("mem_addr", mem_addr, pt_base + {10'd0, m_va[31:12], 2'b00});
  end

  // ---------------- page-table memory responder ----------------
  int          rcnt = 0;
  logic [31:0] raddr = '0;

  always @(negedge clk) begin
    int vpn;
    mem_rsp_valid = 1'b0;
    if (mem_req) begin
      raddr = mem_addr; rcnt = 3;
    end else if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin
        vpn = int'((raddr - pt_base) >> 2);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = ptab.exists(vpn) ? ptab[vpn] : 32'h0;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog (R10) actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input logic [31:0] va, input logic wr);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access_intrude(input logic [31:0] va, input logic [31:0] other);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = 1'b0;
    @(negedge clk);
    req_vaddr = other;            // R10: presented while busy, must be ignored
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    ptab[1] = mk_pte(20'h00ABC, 1, 1, 1);
    ptab[2] = mk_pte(20'h00D00, 1, 1, 0);
    ptab[3] = mk_pte(20'h11111, 0, 1, 1);
    ptab[4] = mk_pte(20'h22222, 1, 0, 1);
    ptab[32'h12345] = mk_pte(20'h5A5A5, 1, 1, 1);
    for (int i = 0; i < 9; i++) ptab[32'h100 + i] = mk_pte(20'h30000 + 20'(i), 1, 1, 1);

    phase = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    phase = "R7"; access(32'h0000_1234, 0);            // fill, expect 00ABC234
    phase = "R2"; access(32'h0000_1FF0, 0);            // hit read
                  access(32'h0000_1004, 1);            // hit write
    phase = "R3"; access(32'h0000_2008, 0);            // read-only page fill
                  access(32'h0000_2010, 1);            // hit, write forbidden
    phase = "R5"; access(32'h0000_3000, 0);            // invalid entry
                  access(32'h0000_3000, 1);            // walks again
    phase = "R6"; access(32'h0000_4ABC, 0);            // no read flag
                  access(32'h0000_4ABC, 0);            // walks again
                  access(32'h0000_4ABC, 1);            // write permitted, fills
    phase = "R4"; pt_base = 32'h0010_0000;
                  access(32'h1234_5678, 1);
    phase = "R9"; do_flush();
                  access(32'h0000_1234, 0);            // must walk again
    phase = "R8"; do_flush();
    for (int i = 0; i < 9; i++) access({20'h00100 + 20'(i), 12'h010}, 0);
                  access(32'h0010_0010, 0);            // first fill was evicted
                  access(32'h0010_8020, 0);            // last fill still hits
    phase = "R10"; access_intrude(32'h0000_3000, 32'h0010_8020);
                  access(32'h0010_8044, 1);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule